// File: doc/BRIEF.md
# Start-up and Auto-Restart Supervisor

This block sequences an off-line switching controller from the moment the bulk input appears until it shuts down. It watches four digitized supply comparator flags and a fault request. From these it drives the high-voltage charger that fills the VDD capacitor, and it selects the charge current. It enables power switching and hands the current-limit stage a 6-bit soft-start code that rises evenly from zero to full scale.

When a fault stops switching, the supervisor keeps the charger off until VDD falls below the low restart level. It then recharges with the reduced current, which makes the hiccup repetition period long. If the bulk input is below the start level when VDD reaches the restart level, the supervisor goes idle instead, and power-down is complete. A fault memory selects the reduced current. A start that completes its soft-start without a fault clears it, and so does a complete power-down.

Top module: `startup_supervisor`

## Requirements
- R1: While `rst_n` is low at a clock edge, the block returns to idle: `chg_en`, `chg_low` and `sw_en` are 0, `ilim_code` is 0 and the fault memory is clear.
- R2: From idle, charging starts one cycle after `bulk_ok` and `vdd_below_rst` are both 1. While charging, `chg_en` follows `bulk_ok`.
- R3: While charging, `vdd_above_on` = 1 starts switching in the next cycle: `sw_en` = 1, `chg_en` = 0 and `ilim_code` = 0. `chg_en` and `sw_en` are never 1 together.
- R4: During soft-start, `ilim_code` rises by one every `CLK_PER_TICK*TICKS_PER_STEP` cycles. After it reaches 63, the next cycle enters run, where `ilim_code` holds at 63.
- R5: While switching, `fault_req` = 1 or `vdd_below_off` = 1 makes `sw_en` = 0 and `ilim_code` = 0 in the next cycle.
- R6: After switching stops, `chg_en` stays 0 until `vdd_below_rst` = 1. Charging then resumes one cycle later if `bulk_ok` = 1.
- R7: If `bulk_ok` = 0 when `vdd_below_rst` is seen after a stop, the block goes idle. It stays uncharged until `bulk_ok` and `vdd_below_rst` are both 1.
- R8: A `fault_req` while switching sets the fault memory. `chg_low` = 1 whenever `chg_en` = 1 and the memory is set. `chg_low` is never 1 without `chg_en`.
- R9: The fault memory clears when soft-start reaches run and when the block goes idle. A stop caused only by `vdd_below_off` leaves it unchanged.
- R10: `fault_req` outside the switching states has no effect on the outputs or on the fault memory.
- R11: Every start and every restart begins soft-start at code 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bulk_ok | input | 1 | Bulk voltage above the start level |
| vdd_above_on | input | 1 | VDD above the turn-on threshold |
| vdd_below_off | input | 1 | VDD below the turn-off threshold |
| vdd_below_rst | input | 1 | VDD below the restart threshold |
| fault_req | input | 1 | Fault request from the protection logic |
| chg_en | output | 1 | High-voltage charger enable |
| chg_low | output | 1 | Selects the reduced charge current |
| sw_en | output | 1 | Power switching enable |
| ilim_code | output | RAMP_BITS | Soft-start current-limit code |

## Verification
The bench builds the block with `CLK_PER_TICK` = 2 and `TICKS_PER_STEP` = 3, so one ramp step takes 6 cycles and a full soft-start takes 378 cycles. This makes it practical to check the exact step edges, the arrival at full scale and the hand-over to run inside one run. It also makes it practical to complete a full start and then exercise the fault-memory clear. With the default parameters, the same checks would take over a million cycles per start.

// File: rtl/sup_pkg.sv
// Shared types for the start-up supervisor.
package sup_pkg;

    // Sequencer states; one switching pair (SOFT, RUN)
    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_CHARGE = 3'd1,
        ST_SOFT   = 3'd2,
        ST_RUN    = 3'd3,
        ST_STOP   = 3'd4
    } sup_state_e;

endpackage

// File: rtl/sup_fsm.sv
// Sequencer: walks idle -> charge -> soft-start -> run -> stop -> (charge | idle).
// Assumes comparator flags are already synchronized to clk.
module sup_fsm
    import sup_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       bulk_ok,
    input  logic       vdd_above_on,
    input  logic       vdd_below_off,
    input  logic       vdd_below_rst,
    input  logic       fault_req,
    input  logic       ramp_full,
    output sup_state_e state,
    output logic       flag_set,
    output logic       flag_clr
);

    sup_state_e state_q, state_d;
    logic       switching;
    logic       stop_req;

    assign switching = (state_q == ST_SOFT) || (state_q == ST_RUN);
    assign stop_req  = fault_req || vdd_below_off;

    // Next-state selection
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (bulk_ok && vdd_below_rst) state_d = ST_CHARGE;
            ST_CHARGE: if (vdd_above_on)             state_d = ST_SOFT;
            ST_SOFT: begin
                if (stop_req)       state_d = ST_STOP;
                else if (ramp_full) state_d = ST_RUN;
            end
            ST_RUN:    if (stop_req)                 state_d = ST_STOP;
            ST_STOP: begin
                if (vdd_below_rst) state_d = bulk_ok ? ST_CHARGE : ST_IDLE;
            end
            default:   state_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Fault memory controls: set on fault while switching, clear on completed start or idle
    always_comb begin
        flag_set = switching && fault_req;
        flag_clr = (state_q == ST_IDLE) ||
                   ((state_q == ST_SOFT) && ramp_full && !stop_req);
    end

    assign state = state_q;

endmodule

// File: rtl/sup_tick.sv
// Prescaler: emits a one-cycle tick every CLK_PER_TICK cycles while enabled.
// Assumes CLK_PER_TICK >= 1; restarts from zero whenever disabled.
module sup_tick #(
    parameter int CLK_PER_TICK = 20
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    output logic tick
);

    localparam int CW = (CLK_PER_TICK > 1) ? $clog2(CLK_PER_TICK) : 1;
    localparam logic [CW-1:0] LAST = CW'(CLK_PER_TICK - 1);

    logic [CW-1:0] cnt_q;

    generate
        if (CLK_PER_TICK == 1) begin : g_direct
            // Every enabled cycle is a tick
            always_ff @(posedge clk) begin
                cnt_q <= '0;
            end
            assign tick = en;
        end else begin : g_count
            // Divide the clock down to the tick rate
            always_ff @(posedge clk) begin
                if (!rst_n || !en)   cnt_q <= '0;
                else if (cnt_q == LAST) cnt_q <= '0;
                else                 cnt_q <= cnt_q + 1'b1;
            end
            assign tick = en && (cnt_q == LAST);
        end
    endgenerate

endmodule

// File: rtl/sup_ramp.sv
// Soft-start ramp: counts TICKS_PER_STEP ticks per code step, from 0 up to
// full scale, then holds. Cleared whenever not enabled.
module sup_ramp #(
    parameter int TICKS_PER_STEP = 1349,
    parameter int RAMP_BITS      = 6
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 en,
    input  logic                 tick,
    output logic [RAMP_BITS-1:0] code,
    output logic                 full
);

    localparam int SW = (TICKS_PER_STEP > 1) ? $clog2(TICKS_PER_STEP) : 1;
    localparam logic [SW-1:0]        STEP_LAST = SW'(TICKS_PER_STEP - 1);
    localparam logic [RAMP_BITS-1:0] CODE_MAX  = '1;

    logic [SW-1:0]        step_q;
    logic [RAMP_BITS-1:0] code_q;
    logic                 step;

    assign full = (code_q == CODE_MAX);
    assign step = tick && (step_q == STEP_LAST);

    // Tick counter within one code step
    always_ff @(posedge clk) begin
        if (!rst_n || !en)  step_q <= '0;
        else if (step)      step_q <= '0;
        else if (tick)      step_q <= step_q + 1'b1;
    end

    // Code register, saturating at full scale
    always_ff @(posedge clk) begin
        if (!rst_n || !en)      code_q <= '0;
        else if (step && !full) code_q <= code_q + 1'b1;
    end

    assign code = code_q;

endmodule

// File: rtl/sup_fault_mem.sv
// Sticky fault memory selecting the reduced charge current. Set wins over clear.
module sup_fault_mem (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    output logic flag
);

    // Hold the flag between a fault and a completed start or power-down
    always_ff @(posedge clk) begin
        if (!rst_n)     flag <= 1'b0;
        else if (set_i) flag <= 1'b1;
        else if (clr_i) flag <= 1'b0;
    end

endmodule

// File: rtl/startup_supervisor.sv
// Start-up and auto-restart supervisor top. Ties together the sequencer, the
// tick prescaler, the soft-start ramp and the fault memory; outputs are decoded
// from registered state. Assumes all inputs are synchronous to clk.
module startup_supervisor
    import sup_pkg::*;
#(
    parameter int CLK_PER_TICK   = 20,
    parameter int TICKS_PER_STEP = 1349,
    parameter int RAMP_BITS      = 6
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 bulk_ok,
    input  logic                 vdd_above_on,
    input  logic                 vdd_below_off,
    input  logic                 vdd_below_rst,
    input  logic                 fault_req,
    output logic                 chg_en,
    output logic                 chg_low,
    output logic                 sw_en,
    output logic [RAMP_BITS-1:0] ilim_code
);

    localparam logic [RAMP_BITS-1:0] CODE_MAX = '1;

    sup_state_e           state;
    logic                 flag_set, flag_clr, fault_flag;
    logic                 in_soft, tick, ramp_full;
    logic [RAMP_BITS-1:0] ramp_code;

    assign in_soft = (state == ST_SOFT);

    sup_fsm u_fsm (
        .clk           (clk),
        .rst_n         (rst_n),
        .bulk_ok       (bulk_ok),
        .vdd_above_on  (vdd_above_on),
        .vdd_below_off (vdd_below_off),
        .vdd_below_rst (vdd_below_rst),
        .fault_req     (fault_req),
        .ramp_full     (ramp_full),
        .state         (state),
        .flag_set      (flag_set),
        .flag_clr      (flag_clr)
    );

    sup_tick #(.CLK_PER_TICK(CLK_PER_TICK)) u_tick (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (in_soft),
        .tick  (tick)
    );

    sup_ramp #(.TICKS_PER_STEP(TICKS_PER_STEP), .RAMP_BITS(RAMP_BITS)) u_ramp (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (in_soft),
        .tick  (tick),
        .code  (ramp_code),
        .full  (ramp_full)
    );

    sup_fault_mem u_fmem (
        .clk   (clk),
        .rst_n (rst_n),
        .set_i (flag_set),
        .clr_i (flag_clr),
        .flag  (fault_flag)
    );

    // Output decode from state
    always_comb begin
        chg_en    = (state == ST_CHARGE) && bulk_ok;
        chg_low   = chg_en && fault_flag;
        sw_en     = (state == ST_SOFT) || (state == ST_RUN);
        ilim_code = (state == ST_RUN)  ? CODE_MAX :
                    (state == ST_SOFT) ? ramp_code : '0;
    end

endmodule

// File: rtl/startup_supervisor_chk.sv
// Checker for startup_supervisor, watching ports only.
module startup_supervisor_chk #(
    parameter int RAMP_BITS = 6
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 fault_req,
    input logic                 vdd_below_off,
    input logic                 chg_en,
    input logic                 chg_low,
    input logic                 sw_en,
    input logic [RAMP_BITS-1:0] ilim_code
);

    logic past_ok;

    // Marks that one post-reset cycle has passed
    always_ff @(posedge clk) begin
        if (!rst_n) past_ok <= 1'b0;
        else        past_ok <= 1'b1;
    end

    // R1
    reset_quiet_chk: assert property (@(posedge clk)
        !rst_n |=> (!chg_en && !sw_en && ilim_code == '0));

    // R3
    chg_sw_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(chg_en && sw_en));

    // R4
    ramp_monotone_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && sw_en && $past(sw_en)) |-> (ilim_code >= $past(ilim_code)));

    // R5
    stop_on_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sw_en && (fault_req || vdd_below_off)) |=> (!sw_en && ilim_code == '0));

    // R8
    low_needs_chg_chk: assert property (@(posedge clk) disable iff (!rst_n)
        chg_low |-> chg_en);

    // R11
    ramp_from_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && $rose(sw_en)) |-> (ilim_code == '0));

endmodule

bind startup_supervisor startup_supervisor_chk #(.RAMP_BITS(RAMP_BITS)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .fault_req     (fault_req),
    .vdd_below_off (vdd_below_off),
    .chg_en        (chg_en),
    .chg_low       (chg_low),
    .sw_en         (sw_en),
    .ilim_code     (ilim_code)
);

// File: tb/tb_startup_supervisor.sv
module tb_startup_supervisor;

    localparam int CPT = 2;
    localparam int TPS = 3;
    localparam int RB  = 6;
    localparam int NV  = 33;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic bulk_ok = 1'b0, vdd_above_on = 1'b0, vdd_below_off = 1'b0;
    logic vdd_below_rst = 1'b0, fault_req = 1'b0;
    logic chg_en, chg_low, sw_en;
    logic [RB-1:0] ilim_code;

    int n_chk = 0;
    int n_fail = 0;
    int cycles = 0;

    always #2.5 clk = ~clk;

    startup_supervisor #(.CLK_PER_TICK(CPT), .TICKS_PER_STEP(TPS), .RAMP_BITS(RB)) dut (
        .clk(clk), .rst_n(rst_n), .bulk_ok(bulk_ok), .vdd_above_on(vdd_above_on),
        .vdd_below_off(vdd_below_off), .vdd_below_rst(vdd_below_rst),
        .fault_req(fault_req), .chg_en(chg_en), .chg_low(chg_low),
        .sw_en(sw_en), .ilim_code(ilim_code)
    );

    // Vector: req[3:0], inputs {bulk,on,off,rst,fault}[4:0], hold[15:0], exp {chg,low,sw,code[5:0]}
    typedef logic [33:0] vec_t;
    localparam vec_t VEC [NV] = '{
        {4'd2,  5'b10010, 16'd1,   9'b100_000000}, // R2 charge starts
        {4'd2,  5'b00010, 16'd1,   9'b000_000000}, // R2 charger follows bulk
        {4'd2,  5'b10000, 16'd1,   9'b100_000000}, // R2
        {4'd3,  5'b11000, 16'd1,   9'b001_000000}, // R3 switching starts
        {4'd4,  5'b11000, 16'd5,   9'b001_000000}, // R4 just before step
        {4'd4,  5'b11000, 16'd1,   9'b001_000001}, // R4 first step
        {4'd4,  5'b11000, 16'd372, 9'b001_111111}, // R4 full scale
        {4'd4,  5'b11000, 16'd1,   9'b001_111111}, // R4 run holds
        {4'd5,  5'b10001, 16'd1,   9'b000_000000}, // R5 fault stops
        {4'd6,  5'b10100, 16'd3,   9'b000_000000}, // R6 wait restart level
        {4'd8,  5'b10110, 16'd1,   9'b110_000000}, // R8 reduced current
        {4'd8,  5'b10100, 16'd2,   9'b110_000000}, // R8
        {4'd11, 5'b11000, 16'd1,   9'b001_000000}, // R11 ramp from 0
        {4'd11, 5'b11000, 16'd6,   9'b001_000001}, // R11
        {4'd5,  5'b10100, 16'd1,   9'b000_000000}, // R5 undervoltage stops
        {4'd9,  5'b10110, 16'd1,   9'b110_000000}, // R9 flag kept
        {4'd3,  5'b11000, 16'd1,   9'b001_000000}, // R3
        {4'd9,  5'b11000, 16'd379, 9'b001_111111}, // R9 start completes
        {4'd5,  5'b10100, 16'd1,   9'b000_000000}, // R5
        {4'd9,  5'b10110, 16'd1,   9'b100_000000}, // R9 flag cleared
        {4'd3,  5'b11000, 16'd1,   9'b001_000000}, // R3
        {4'd5,  5'b10100, 16'd1,   9'b000_000000}, // R5
        {4'd7,  5'b00110, 16'd1,   9'b000_000000}, // R7 power-down
        {4'd7,  5'b00110, 16'd3,   9'b000_000000}, // R7 stays idle
        {4'd7,  5'b10010, 16'd1,   9'b100_000000}, // R7 fresh start
        {4'd10, 5'b10011, 16'd2,   9'b100_000000}, // R10 fault ignored
        {4'd11, 5'b11000, 16'd1,   9'b001_000000}, // R11
        {4'd8,  5'b11001, 16'd1,   9'b000_000000}, // R8 fault in soft-start
        {4'd8,  5'b10010, 16'd1,   9'b110_000000}, // R8
        {4'd3,  5'b11000, 16'd1,   9'b001_000000}, // R3
        {4'd5,  5'b10100, 16'd1,   9'b000_000000}, // R5
        {4'd9,  5'b00110, 16'd1,   9'b000_000000}, // R9 idle
        {4'd9,  5'b10010, 16'd1,   9'b100_000000}  // R9 idle cleared flag
    };

    task automatic check(input int req, input logic [8:0] exp);
        logic [8:0] act;
        act = {chg_en, chg_low, sw_en, ilim_code};
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL R%0d: actual chg=%b low=%b sw=%b code=%0d expected chg=%b low=%b sw=%b code=%0d",
                     req, act[8], act[7], act[6], act[5:0], exp[8], exp[7], exp[6], exp[5:0]);
        end
    endtask

    task automatic drive(input logic [4:0] v);
        {bulk_ok, vdd_above_on, vdd_below_off, vdd_below_rst, fault_req} = v;
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    // Watchdog
    always @(posedge clk) begin
        cycles++;
        if (cycles > 50000) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            finish_run();
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(1, 9'b000_000000); // R1 reset state
        rst_n = 1'b1;
        for (int i = 0; i < NV; i++) begin
            drive(VEC[i][29:25]);
            repeat (int'(VEC[i][24:9])) @(posedge clk);
            @(negedge clk);
            check(int'(VEC[i][33:30]), VEC[i][8:0]);
        end
        // R1: reset in the middle of soft-start
        drive(5'b11000);
        repeat (10) @(posedge clk);
        @(negedge clk);
        check(1, 9'b001_000001);
        rst_n = 1'b0;
        @(posedge clk);
        @(negedge clk);
        check(1, 9'b000_000000);
        rst_n = 1'b1;
        // R2: idle needs both bulk and restart level
        drive(5'b10000);
        repeat (2) @(posedge clk);
        @(negedge clk);
        check(2, 9'b000_000000);
        finish_run();
    end

endmodule